// File: doc/BRIEF.md
# Dispatch Group Slot Tracker

This block follows the filling of a single instruction dispatch group, one candidate at a time. Every cycle the scheduler presents a candidate instruction as a unit class plus three flags. The flags mark an instruction that must take slot zero, an instruction that occupies the whole group, and an instruction the decoder splits into two internal operations. The tracker answers at once, without a clock edge, with a two-bit hazard code. The code says whether the candidate may join the group now, must wait for a fresh group, or may join only after a no-op has been inserted.

Once the scheduler commits an instruction it pulses the issue strobe, with the same candidate fields still applied. To burn one slot without issuing anything it pulses the empty-cycle strobe. The tracker keeps the count of occupied slots in a register. When the count reaches the group size, the tracker closes the group, returns the count to zero and pulses a group-done flag. Any event that would push the count beyond the group size sets a sticky overfill error.

Top module: `dgst_tracker`

## Requirements
- R1: A synchronous active-high reset sets the slot count to 0 and clears group_done and overfill_err. Hazard codes are 00 none, 01 stall and 10 insert-no-op.
- R2: A class code of 0 (pseudo) always gives hazard 00 whatever its flags and the count. Issuing it leaves the slot count unchanged.
- R3: A candidate flagged first_only or fills_group gives stall (01) whenever the slot count is not zero.
- R4: A cracked candidate gives stall when more than two slots are occupied. Issuing it adds two to the count.
- R5: Class codes 1 to 5 (integer, load/store, floating point, vector ALU, vector permute) give stall when four slots are occupied. Issuing one adds one.
- R6: Class code 6 (condition register) gives stall once two or more slots are occupied.
- R7: Class code 7 (branch) is never stalled for slot reasons. Issuing a branch or a fills_group instruction closes the group: the count reads 0 after that edge and group_done is 1 for exactly one cycle.
- R8: An empty-cycle strobe without an issue adds one slot. The fifth slot closes the group: the count returns to 0 and group_done pulses.
- R9: A candidate with flush_risk set that would otherwise give 00 gives 10. A stall outranks the no-op code.
- R10: When the issue and empty-cycle strobes are both high in one cycle, only the issue is applied and the empty cycle is discarded.
- R11: An issue that would take the count past five sets overfill_err. The group is then closed, and the flag stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_class | input | 3 | Unit class code of the candidate (0 pseudo .. 7 branch) |
| cand_first_only | input | 1 | Candidate may only take slot zero |
| cand_fills_group | input | 1 | Candidate occupies the whole group |
| cand_cracked | input | 1 | Candidate splits into two operations |
| cand_flush_risk | input | 1 | Candidate would cause a flush inside this group |
| issue_strobe | input | 1 | The candidate on the inputs is issued this cycle |
| empty_strobe | input | 1 | This cycle passes with no issue and uses one slot |
| hazard | output | 2 | Combinational verdict for the candidate |
| slot_count | output | 3 | Registered number of occupied slots |
| group_done | output | 1 | One-cycle pulse after a group closes |
| overfill_err | output | 1 | Sticky overfill error |

## Verification
The issue strobe and the empty-cycle strobe can both arrive in the same cycle. The bench provokes this by raising both strobes on one edge with a one-slot integer candidate at a count of one. It then expects the count to read two, not three, on the next sample. A second case drives both strobes with a branch candidate. There the bench expects a count of zero and a single group_done pulse, with no leftover slot counted into the new group.

// File: rtl/dgst_pkg.sv
package dgst_pkg;
  typedef enum logic [2:0] {
    CLS_PSEUDO = 3'd0,
    CLS_INT    = 3'd1,
    CLS_LSU    = 3'd2,
    CLS_FPU    = 3'd3,
    CLS_VALU   = 3'd4,
    CLS_VPERM  = 3'd5,
    CLS_CR     = 3'd6,
    CLS_BR     = 3'd7
  } cls_e;

  typedef enum logic [1:0] {
    HZ_NONE  = 2'b00,
    HZ_STALL = 2'b01,
    HZ_NOOP  = 2'b10
  } hazard_e;

  function automatic logic is_exec_class(cls_e c);
    return (c == CLS_INT) || (c == CLS_LSU) || (c == CLS_FPU) ||
           (c == CLS_VALU) || (c == CLS_VPERM);
  endfunction
endpackage

// File: rtl/dgst_slot_rules.sv
module dgst_slot_rules
  import dgst_pkg::*;
#(
  parameter int NUM_SLOTS   = 5,
  parameter int CR_LIMIT    = 2,
  parameter int CRACK_SLOTS = 2,
  localparam int CW = $clog2(NUM_SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  cls_e          cls,
  input  logic          first_only,
  input  logic          fills_group,
  input  logic          cracked,
  input  logic          flush_risk,
  input  logic [CW-1:0] count,
  output hazard_e       hazard
);
  localparam int LAST_SLOT = NUM_SLOTS - 1;

  logic slot_zero_bad;
  logic crack_bad;
  logic exec_bad;
  logic cr_bad;
  logic any_stall;

  always_comb begin
    slot_zero_bad = (first_only || fills_group) && (count != '0);
    crack_bad     = cracked && ((int'(count) + CRACK_SLOTS) > LAST_SLOT);
    exec_bad      = is_exec_class(cls) && (int'(count) >= LAST_SLOT);
    cr_bad        = (cls == CLS_CR) && (int'(count) >= CR_LIMIT);
    any_stall     = slot_zero_bad || crack_bad || exec_bad || cr_bad;
  end

  always_comb begin
    if (cls == CLS_PSEUDO)   hazard = HZ_NONE;
    else if (any_stall)      hazard = HZ_STALL;
    else if (flush_risk)     hazard = HZ_NOOP;
    else                     hazard = HZ_NONE;
  end

  // R6: condition-register work never accepted past the limit
  assert_cr_limit_R6: assert property (@(posedge clk) disable iff (rst)
    (cls == CLS_CR && int'(count) >= CR_LIMIT) |-> (hazard == HZ_STALL));

  // R7: branches are never refused for slot reasons
  assert_branch_free_R7: assert property (@(posedge clk) disable iff (rst)
    (cls == CLS_BR && !first_only && !fills_group && !cracked) |-> (hazard != HZ_STALL));

  // R2: pseudo candidates are transparent
  assert_pseudo_none_R2: assert property (@(posedge clk) disable iff (rst)
    (cls == CLS_PSEUDO) |-> (hazard == HZ_NONE));
endmodule

// File: rtl/dgst_slot_counter.sv
module dgst_slot_counter
  import dgst_pkg::*;
#(
  parameter int NUM_SLOTS   = 5,
  parameter int CRACK_SLOTS = 2,
  localparam int CW = $clog2(NUM_SLOTS + 1),
  localparam int SW = CW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic          empty,
  input  cls_e          cls,
  input  logic          fills_group,
  input  logic          cracked,
  output logic [CW-1:0] count,
  output logic          done,
  output logic          err
);
  localparam logic [SW-1:0] GROUP = SW'(NUM_SLOTS);
  localparam logic [SW-1:0] EXTRA = SW'(CRACK_SLOTS - 1);

  logic [SW-1:0] base;
  logic [SW-1:0] sum;
  logic          touch;
  logic          closes;
  logic          overflows;

  always_comb begin
    base  = SW'(count);
    sum   = base;
    touch = 1'b0;
    if (issue) begin
      if (cls != CLS_PSEUDO) begin
        touch = 1'b1;
        if (cls == CLS_BR || fills_group) base = GROUP - 1'b1;
        sum = base + 1'b1 + (cracked ? EXTRA : '0);
      end
    end else if (empty) begin
      touch = 1'b1;
      sum   = base + 1'b1;
    end
    closes    = touch && (sum >= GROUP);
    overflows = touch && (sum > GROUP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= closes;
      if (closes)     count <= '0;
      else if (touch) count <= sum[CW-1:0];
      if (overflows)  err <= 1'b1;
    end
  end

  // R8: the count never rests on a full group
  assert_count_range_R8: assert property (@(posedge clk) disable iff (rst)
    int'(count) < NUM_SLOTS);

  // R7: a done pulse always coincides with a fresh group
  assert_done_empty_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (count == '0));

  // R11: overfill error is sticky
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  // R2: a pseudo issue leaves the count alone
  assert_pseudo_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (issue && cls == CLS_PSEUDO) |=> $stable(count));

  // R8: an empty cycle below the last slot adds one
  assert_empty_step_R8: assert property (@(posedge clk) disable iff (rst)
    (empty && !issue && int'(count) < NUM_SLOTS - 1) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/dgst_tracker.sv
module dgst_tracker
  import dgst_pkg::*;
#(
  parameter int NUM_SLOTS   = 5,
  parameter int CR_LIMIT    = 2,
  parameter int CRACK_SLOTS = 2,
  localparam int CW = $clog2(NUM_SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    cand_class,
  input  logic          cand_first_only,
  input  logic          cand_fills_group,
  input  logic          cand_cracked,
  input  logic          cand_flush_risk,
  input  logic          issue_strobe,
  input  logic          empty_strobe,
  output logic [1:0]    hazard,
  output logic [CW-1:0] slot_count,
  output logic          group_done,
  output logic          overfill_err
);
  cls_e    cls;
  hazard_e hz;

  assign cls    = cls_e'(cand_class);
  assign hazard = hz;

  dgst_slot_rules #(
    .NUM_SLOTS  (NUM_SLOTS),
    .CR_LIMIT   (CR_LIMIT),
    .CRACK_SLOTS(CRACK_SLOTS)
  ) u_rules (
    .clk        (clk),
    .rst        (rst),
    .cls        (cls),
    .first_only (cand_first_only),
    .fills_group(cand_fills_group),
    .cracked    (cand_cracked),
    .flush_risk (cand_flush_risk),
    .count      (slot_count),
    .hazard     (hz)
  );

  dgst_slot_counter #(
    .NUM_SLOTS  (NUM_SLOTS),
    .CRACK_SLOTS(CRACK_SLOTS)
  ) u_counter (
    .clk        (clk),
    .rst        (rst),
    .issue      (issue_strobe),
    .empty      (empty_strobe),
    .cls        (cls),
    .fills_group(cand_fills_group),
    .cracked    (cand_cracked),
    .count      (slot_count),
    .done       (group_done),
    .err        (overfill_err)
  );

  // R1: hazard code 11 is never produced
  assert_hazard_legal_R1: assert property (@(posedge clk) disable iff (rst)
    hazard != 2'b11);

  // R10: simultaneous strobes never add more than one slot from a one-slot issue
  assert_dual_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    (issue_strobe && empty_strobe && cls == CLS_INT && !cand_cracked && slot_count == 3'd1)
      |=> (slot_count == 3'd2));
endmodule

// File: tb/test_dgst_tracker.sv
module test_dgst_tracker;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cand_class = 3'd0;
  logic       cand_first_only = 1'b0;
  logic       cand_fills_group = 1'b0;
  logic       cand_cracked = 1'b0;
  logic       cand_flush_risk = 1'b0;
  logic       issue_strobe = 1'b0;
  logic       empty_strobe = 1'b0;
  logic [1:0] hazard;
  logic [2:0] slot_count;
  logic       group_done;
  logic       overfill_err;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  dgst_tracker i_dgst_tracker (
    .clk(clk), .rst(rst), .cand_class(cand_class),
    .cand_first_only(cand_first_only), .cand_fills_group(cand_fills_group),
    .cand_cracked(cand_cracked), .cand_flush_risk(cand_flush_risk),
    .issue_strobe(issue_strobe), .empty_strobe(empty_strobe),
    .hazard(hazard), .slot_count(slot_count),
    .group_done(group_done), .overfill_err(overfill_err)
  );

  // entry: cls[15:13] first[12] fill[11] crack[10] risk[9] pre[8:6] exp[5:4]
  localparam int NV = 18;
  localparam logic [15:0] VEC [NV] = '{
    {3'd1,1'b0,1'b0,1'b0,1'b0,3'd0,2'b00,4'h0},  // R5 int at 0
    {3'd1,1'b0,1'b0,1'b0,1'b0,3'd3,2'b00,4'h0},  // R5 int at 3
    {3'd1,1'b0,1'b0,1'b0,1'b0,3'd4,2'b01,4'h0},  // R5 int at 4
    {3'd2,1'b0,1'b0,1'b0,1'b0,3'd4,2'b01,4'h0},  // R5 lsu at 4
    {3'd5,1'b0,1'b0,1'b0,1'b0,3'd4,2'b01,4'h0},  // R5 vperm at 4
    {3'd7,1'b0,1'b0,1'b0,1'b0,3'd4,2'b00,4'h0},  // R7 branch at 4
    {3'd6,1'b0,1'b0,1'b0,1'b0,3'd1,2'b00,4'h0},  // R6 cr at 1
    {3'd6,1'b0,1'b0,1'b0,1'b0,3'd2,2'b01,4'h0},  // R6 cr at 2
    {3'd1,1'b1,1'b0,1'b0,1'b0,3'd0,2'b00,4'h0},  // R3 first at 0
    {3'd1,1'b1,1'b0,1'b0,1'b0,3'd1,2'b01,4'h0},  // R3 first at 1
    {3'd3,1'b0,1'b1,1'b0,1'b0,3'd2,2'b01,4'h0},  // R3 fill at 2
    {3'd1,1'b0,1'b0,1'b1,1'b0,3'd2,2'b00,4'h0},  // R4 cracked at 2
    {3'd2,1'b0,1'b0,1'b1,1'b0,3'd3,2'b01,4'h0},  // R4 cracked at 3
    {3'd1,1'b0,1'b0,1'b0,1'b1,3'd1,2'b10,4'h0},  // R9 risk at 1
    {3'd1,1'b0,1'b0,1'b0,1'b1,3'd4,2'b01,4'h0},  // R9 stall outranks
    {3'd7,1'b0,1'b0,1'b0,1'b1,3'd3,2'b10,4'h0},  // R9 branch with risk
    {3'd0,1'b1,1'b0,1'b1,1'b1,3'd3,2'b00,4'h0},  // R2 pseudo flags
    {3'd4,1'b0,1'b0,1'b0,1'b0,3'd2,2'b00,4'h0}   // R5 valu at 2
  };

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    issue_strobe = 1'b0; empty_strobe = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_cand(input logic [2:0] c, input logic f, input logic g,
                          input logic k, input logic r);
    cand_class = c; cand_first_only = f; cand_fills_group = g;
    cand_cracked = k; cand_flush_risk = r;
  endtask

  task automatic pulse(input logic iss, input logic emp);
    issue_strobe = iss; empty_strobe = emp;
    @(negedge clk);
    issue_strobe = 1'b0; empty_strobe = 1'b0;
  endtask

  task automatic empties(input int n);
    for (int i = 0; i < n; i++) pulse(1'b0, 1'b1);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    check(slot_count, 0, "R1 count after reset");
    check(group_done, 0, "R1 done after reset");
    check(overfill_err, 0, "R1 err after reset");
    check(hazard, 0, "R1 pseudo hazard after reset");

    for (int v = 0; v < NV; v++) begin
      do_reset();
      set_cand(3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      empties(int'(VEC[v][8:6]));
      set_cand(VEC[v][15:13], VEC[v][12], VEC[v][11], VEC[v][10], VEC[v][9]);
      #1;
      check(hazard, int'(VEC[v][5:4]), $sformatf("R2-9 vector %0d hazard", v));
    end

    // R5 / R4 issue increments
    do_reset();
    set_cand(3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    pulse(1'b1, 1'b0);
    check(slot_count, 1, "R5 int issue adds one");
    set_cand(3'd2, 1'b0, 1'b0, 1'b1, 1'b0);
    pulse(1'b1, 1'b0);
    check(slot_count, 3, "R4 cracked issue adds two");

    // R2 pseudo issue holds count
    set_cand(3'd0, 1'b1, 1'b1, 1'b1, 1'b0);
    pulse(1'b1, 1'b0);
    check(slot_count, 3, "R2 pseudo issue keeps count");
    check(group_done, 0, "R2 pseudo issue no close");

    // R7 branch closes group
    set_cand(3'd7, 1'b0, 1'b0, 1'b0, 1'b0);
    pulse(1'b1, 1'b0);
    check(slot_count, 0, "R7 branch closes count");
    check(group_done, 1, "R7 branch done pulse");
    @(negedge clk);
    check(group_done, 0, "R7 done lasts one cycle");

    // R7 fill closes group from zero
    set_cand(3'd1, 1'b0, 1'b1, 1'b0, 1'b0);
    pulse(1'b1, 1'b0);
    check(slot_count, 0, "R7 fill closes count");
    check(group_done, 1, "R7 fill done pulse");

    // R8 empty cycles
    do_reset();
    empties(4);
    check(slot_count, 4, "R8 four empties");
    check(group_done, 0, "R8 no close at four");
    empties(1);
    check(slot_count, 0, "R8 fifth empty closes");
    check(group_done, 1, "R8 fifth empty done");

    // R10 simultaneous strobes
    do_reset();
    empties(1);
    set_cand(3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    pulse(1'b1, 1'b1);
    check(slot_count, 2, "R10 empty discarded with issue");
    set_cand(3'd7, 1'b0, 1'b0, 1'b0, 1'b0);
    pulse(1'b1, 1'b1);
    check(slot_count, 0, "R10 branch plus empty count");
    check(group_done, 1, "R10 branch plus empty done");
    @(negedge clk);
    check(slot_count, 0, "R10 no leftover slot");
    check(group_done, 0, "R10 single done pulse");

    // R11 overfill
    do_reset();
    empties(4);
    set_cand(3'd1, 1'b0, 1'b0, 1'b1, 1'b0);
    pulse(1'b1, 1'b0);
    check(overfill_err, 1, "R11 overfill sets err");
    check(slot_count, 0, "R11 overfill closes group");
    set_cand(3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    empties(3);
    check(overfill_err, 1, "R11 err sticky");
    do_reset();
    #1;
    check(overfill_err, 0, "R11 reset clears err");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule